// File: doc/BRIEF.md
# Serial Interrupt Bus Slot Agent

This block is the device-side agent on a single-wire, open-drain serialized interrupt bus. It follows the shared line, recognizes the long low pulse that opens a frame, and then counts three-clock slots. In the slot selected by a parameter it reports the level of one local interrupt input. It pulls the line low when that input is low, actively restores the line high on the next clock, and then lets go of it.

The agent also measures the low pulse that closes each frame and uses its width to choose the bus mode. In continuous mode only the host opens frames. In quiet mode the agent can ask for a frame when its interrupt level no longer matches the level it last reported. It does this by holding the line low for a single clock, and the host then extends that pulse into a full start pulse.

The line appears at the ports as a sampled input plus a drive-enable and a drive-value output. The pad or board logic forms the wired-AND.

Top module: `sirq_slot_agent`

## Requirements
- R1: After reset, `drv_en` is 0 and `mode_quiet` is 0, which selects continuous mode.
- R2: A frame opens when `line_in` has been sampled low on at least START_MIN (4) consecutive clock edges while the agent is idle and is then sampled high. The clock period right after that first high sample is the sample phase of slot 0.
- R3: A low pulse on an idle line that is sampled on fewer than START_MIN edges opens no frame, so the agent drives nothing afterwards.
- R4: Slot s takes relative clocks 3s (sample), 3s+1 (recovery) and 3s+2 (turn-around). In the sample phase of slot SLOT_IDX the agent drives 0 (`drv_en`=1, `drv_val`=0) if `irq_in` was low at the preceding clock edge. If it was high, the agent leaves the line released.
- R5: In the recovery phase of its own slot the agent drives 1 (`drv_en`=1, `drv_val`=1) only if it drove 0 in the sample phase just before. Otherwise it stays released.
- R6: `drv_en` is 0 in the turn-around phase and in every clock outside its own sample and recovery phases. The only exception is the single request clock of R9.
- R7: If the low pulse after the last slot is sampled on exactly 2 edges, `mode_quiet` becomes 1. The change is visible in the clock after the line is sampled high again.
- R8: If that low pulse is sampled on exactly 3 edges, `mode_quiet` becomes 0 with the same timing. Other widths leave the mode unchanged.
- R9: In quiet mode, with the agent idle and the line sampled high, a registered `irq_in` that differs from the level sent in the agent's last own sample phase makes the agent drive 0 for exactly one clock. This happens two clocks after `irq_in` changes, and the agent then releases the line. While the registered input equals the last reported level, there is no request.
- R10: In continuous mode a change of `irq_in` while idle never causes a drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Sampled level of the shared interrupt line |
| irq_in | input | 1 | Local interrupt level; low means the line is pulled low in the slot |
| drv_en | output | 1 | Enables the agent's driver onto the line |
| drv_val | output | 1 | Value driven while `drv_en` is 1 |
| mode_quiet | output | 1 | 1 for quiet mode, 0 for continuous mode |

## Verification
If the slot counter or the phase is off by one, the drive appears in the wrong relative clock of the very next frame. Per-clock comparison of `drv_en` across the whole frame catches it within one frame. A stale "pulled low" flag shows up as a recovery-phase high drive after a released sample phase, in the same slot.

A wrong mode register or a wrong reported level only shows up later, either as a missing request clock or as a spurious one while idle. That is why every scenario ends with an idle window in which `drv_en` is watched.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_START,
    ST_SLOTS,
    ST_STOPW
  } agent_st_e;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_RECOV  = 2'd1,
    PH_TURN   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    STOP_NONE,
    STOP_QUIET,
    STOP_CONT
  } stop_kind_e;

  // phase order inside one slot
  function automatic phase_e next_phase(phase_e p);
    case (p)
      PH_SAMPLE: next_phase = PH_RECOV;
      PH_RECOV:  next_phase = PH_TURN;
      default:   next_phase = PH_SAMPLE;
    endcase
  endfunction

  // low pulse long enough to open a frame
  function automatic logic is_start_len(int unsigned len, int unsigned min_len);
    is_start_len = (len >= min_len);
  endfunction

  // closing pulse width -> next bus mode
  function automatic stop_kind_e decode_stop(int unsigned len);
    case (len)
      2:       decode_stop = STOP_QUIET;
      3:       decode_stop = STOP_CONT;
      default: decode_stop = STOP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sirq_low_meter.sv
module sirq_low_meter #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic             rise_seen,
  output logic [LEN_W-1:0] low_len
);

  logic [LEN_W-1:0] cnt_q;

  // count consecutive low samples, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!line_in) begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign rise_seen = line_in && (cnt_q != '0);
  assign low_len   = cnt_q;

  AST_LEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    line_in |=> (low_len == '0)); // R2

endmodule

// File: rtl/sirq_slot_timer.sv
module sirq_slot_timer
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 21,
  parameter int SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              run,
  output logic [SLOT_W-1:0] slot_q,
  output phase_e            phase_q,
  output logic              last_tick
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= PH_SAMPLE;
    end else if (launch) begin
      slot_q  <= '0;
      phase_q <= PH_SAMPLE;
    end else if (run) begin
      phase_q <= next_phase(phase_q);
      if (phase_q == PH_TURN && slot_q != LAST_SLOT) slot_q <= slot_q + 1'b1;
    end
  end

  assign last_tick = run && (slot_q == LAST_SLOT) && (phase_q == PH_TURN);

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !launch && phase_q == PH_TURN && !last_tick)
      |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1))); // R4
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q inside {PH_SAMPLE, PH_RECOV, PH_TURN}); // R4

endmodule

// File: rtl/sirq_drive_ctl.sv
module sirq_drive_ctl
  import sirq_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int SLOT_IDX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_slots,
  input  logic              in_req,
  input  logic [SLOT_W-1:0] slot_q,
  input  phase_e            phase_q,
  input  logic              irq_lvl,
  output logic              drv_en,
  output logic              drv_val,
  output logic              own_sample,
  output logic              own_recov,
  output logic              own_turn,
  output logic              rep_lvl
);

  logic own_slot;
  logic pulled_low_q;

  assign own_slot   = in_slots && (slot_q == SLOT_W'(SLOT_IDX));
  assign own_sample = own_slot && (phase_q == PH_SAMPLE);
  assign own_recov  = own_slot && (phase_q == PH_RECOV);
  assign own_turn   = own_slot && (phase_q == PH_TURN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulled_low_q <= 1'b0;
      rep_lvl      <= 1'b1;
    end else if (own_sample) begin
      pulled_low_q <= !irq_lvl;
      rep_lvl      <= irq_lvl;
    end else if (own_turn) begin
      pulled_low_q <= 1'b0;
    end
  end

  assign drv_en  = in_req || (own_sample && !irq_lvl) || (own_recov && pulled_low_q);
  assign drv_val = own_recov && pulled_low_q;

  AST_SAMPLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (own_sample && drv_en) |-> !drv_val); // R4
  AST_RECOV_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (own_recov && drv_en) |-> $past(drv_en && !drv_val)); // R5
  AST_TURN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    own_turn |-> !drv_en); // R6

endmodule

// File: rtl/sirq_slot_agent.sv
module sirq_slot_agent
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 21,
  parameter int SLOT_IDX  = 5,
  parameter int START_MIN = 4,
  parameter int LEN_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic irq_in,
  output logic drv_en,
  output logic drv_val,
  output logic mode_quiet
);

  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  agent_st_e         state_q, state_d;
  logic              irq_q;
  logic              mode_q;
  logic              rise_seen;
  logic [LEN_W-1:0]  low_len;
  logic [SLOT_W-1:0] slot_q;
  phase_e            phase_q;
  logic              last_tick;
  logic              own_sample, own_recov, own_turn;
  logic              rep_lvl;
  logic              req_cond, start_ok;
  stop_kind_e        stop_kind;

  sirq_low_meter #(.LEN_W(LEN_W)) meter_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .rise_seen(rise_seen), .low_len(low_len)
  );

  sirq_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .launch(start_ok), .run(state_q == ST_SLOTS),
    .slot_q(slot_q), .phase_q(phase_q), .last_tick(last_tick)
  );

  sirq_drive_ctl #(.SLOT_W(SLOT_W), .SLOT_IDX(SLOT_IDX)) drive_i (
    .clk(clk), .rst_n(rst_n), .in_slots(state_q == ST_SLOTS),
    .in_req(state_q == ST_REQ), .slot_q(slot_q), .phase_q(phase_q),
    .irq_lvl(irq_q), .drv_en(drv_en), .drv_val(drv_val),
    .own_sample(own_sample), .own_recov(own_recov), .own_turn(own_turn),
    .rep_lvl(rep_lvl)
  );

  assign req_cond  = mode_q && (state_q == ST_IDLE) && line_in && (irq_q != rep_lvl);
  assign start_ok  = (state_q == ST_START) && rise_seen &&
                     is_start_len(32'(low_len), START_MIN);
  assign stop_kind = decode_stop(32'(low_len));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_cond) state_d = ST_REQ;
                else if (!line_in) state_d = ST_START;
      ST_REQ:   state_d = ST_START;
      ST_START: if (rise_seen) state_d = start_ok ? ST_SLOTS : ST_IDLE;
      ST_SLOTS: if (last_tick) state_d = ST_STOPW;
      ST_STOPW: if (rise_seen) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_in;
      if (state_q == ST_STOPW && rise_seen) begin
        if (stop_kind == STOP_QUIET)     mode_q <= 1'b1;
        else if (stop_kind == STOP_CONT) mode_q <= 1'b0;
      end
    end
  end

  assign mode_quiet = mode_q;

  AST_DRIVE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (state_q == ST_REQ || own_sample || own_recov)); // R6
  AST_REQ_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ) |=> (state_q == ST_START && !drv_en)); // R9
  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ) |-> mode_quiet); // R9
  AST_CONT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_quiet && state_q == ST_IDLE) |=> (state_q != ST_REQ)); // R10
  AST_TURN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    own_turn |-> !drv_en); // R6

endmodule

// File: tb/sirq_slot_agent_tb_top.sv
module sirq_slot_agent_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 21;
  localparam int SI = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic irq_in = 1'b1;
  logic line_in, drv_en, drv_val, mode_quiet;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_in = host_low ? 1'b0 : (drv_en ? drv_val : 1'b1);

  sirq_slot_agent #(.NUM_SLOTS(NS), .SLOT_IDX(SI)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .irq_in(irq_in),
    .drv_en(drv_en), .drv_val(drv_val), .mode_quiet(mode_quiet)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // host holds line low for len sampled edges; caller sits at a negedge
  task automatic host_pulse(int len);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
  endtask

  // R4 R5 R6: compare every clock of the frame; lvl = irq level at sample
  task automatic run_frame(logic lvl);
    for (int t = 0; t < 3*NS; t++) begin
      logic e_en;
      @(negedge clk);
      e_en = !lvl && (t == 3*SI || t == 3*SI + 1);
      chk(t == 3*SI ? "R4" : (t == 3*SI + 1 ? "R5" : "R6"), drv_en, e_en);
      if (e_en) chk(t == 3*SI ? "R4" : "R5", drv_val, (t == 3*SI + 1));
    end
  endtask

  task automatic close_frame(int w, logic exp_mode, string req);
    @(negedge clk);
    host_pulse(w);
    @(negedge clk);
    chk(req, mode_quiet, exp_mode);
  endtask

  task automatic idle_quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, drv_en, 1'b0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", drv_en, 1'b0);
    chk("R1", mode_quiet, 1'b0);
  endtask

  task automatic t_frame_high_cont;
    irq_in = 1'b1;
    @(negedge clk);
    host_pulse(4);          // R2 minimum start width
    run_frame(1'b1);
    close_frame(3, 1'b0, "R8");
  endtask

  task automatic t_frame_low_to_quiet;
    irq_in = 1'b0;
    idle_quiet(3, "R10");
    host_pulse(6);          // R2 longer start
    run_frame(1'b0);
    close_frame(2, 1'b1, "R7");
  endtask

  task automatic t_quiet_request;
    idle_quiet(6, "R9");    // level already reported, no request
    irq_in = 1'b1;
    @(negedge clk);
    chk("R9", drv_en, 1'b0);
    @(negedge clk);
    chk("R9", drv_en, 1'b1);
    chk("R9", drv_val, 1'b0);
    host_low = 1'b1;
    @(negedge clk);
    chk("R9", drv_en, 1'b0);
    repeat (3) @(negedge clk);
    host_low = 1'b0;
    run_frame(1'b1);
    close_frame(3, 1'b0, "R8");
  endtask

  task automatic t_cont_no_request;
    irq_in = 1'b0;
    idle_quiet(8, "R10");
  endtask

  task automatic t_short_pulse;
    @(negedge clk);
    host_pulse(3);
    idle_quiet(3*NS + 3, "R3");
    host_pulse(5);
    run_frame(1'b0);
    close_frame(5, 1'b0, "R8");   // other width: mode kept
    idle_quiet(4, "R10");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame_high_cont();
    t_frame_low_to_quiet();
    t_quiet_request();
    t_cont_no_request();
    t_short_pulse();
    finish_run();
  end

endmodule